// File: doc/BRIEF.md
# Far-End Fault Pattern Detector

This block watches a received serial bit stream, one bit per clock while a valid strobe is high, for the code that a link partner sends to report a fault at its end. The code is a long run of ones closed by a single zero, repeated back to back. When enough such groups arrive in a row, the block raises a sticky remote-fault flag and takes the link down.

The flags are read through a small synchronous read port that stands in for management access. A single status word holds the remote-fault flag and a link flag that stays low once it has dropped. Reading the status word clears the remote-fault flag and updates the link flag. If the fault code keeps arriving, the remote-fault flag sets again after every further complete detection, so a fault that lasts is never hidden by an earlier read. The link comes back only after one full group length of stream with no complete group in it.

Top module: `far_fault_det`

## Requirements
- R1: A code group is exactly 84 consecutive valid ones followed by one valid zero. A valid zero that closes a run of any other length resets the count of consecutive groups to zero.
- R2: A fault is declared only on the closing zero of the third group in an unbroken series. Two groups, or three groups with a bad run among them, declare nothing. After a declaration the group count restarts from zero.
- R3: A declaration sets the remote-fault flag. The flag reads as bit 4 of the status word at address 1.
- R4: A declaration drops the live link state and the latched link flag. The latched link flag reads as bit 2 of the status word.
- R5: A read of address 1 clears the remote-fault flag. If a declaration falls in the same cycle as the read, that read returns the old flag value and the flag is left set.
- R6: While the fault code persists, every further three-group detection sets the remote-fault flag again, including after a read has cleared it.
- R7: The link flag is latch-low. A read returns the latched value and then loads the live link state, so the first read after a drop returns 0 and later reads follow the live state.
- R8: The live link state rises one cycle after 85 consecutive valid bits have passed without a complete group, counted from reset or from the last group.
- R9: A synchronous active-high reset clears all counters, the remote-fault flag, the live link state, the link flag and the read data.
- R10: A read of any address other than 1 returns zero and changes no flag.
- R11: Cycles with the valid strobe low are ignored. They neither extend nor break a run.
- R12: Read data appears in the cycle after the read strobe and is zero in every cycle that follows no read of address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Received serial bit |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data, registered |

## Verification
The stream is driven with runs of 83, 84 and 85 ones. This shows that only the exact length counts as a group and that a bad run in the middle restarts the count. Two groups and three groups are sent to mark the declaration threshold. One series has valid-low gaps scattered through it, to show that idle cycles neither break nor extend a run. A continued fault series, with a read landing on the declaring zero, shows that the flag sets again and that the set takes priority over the clear. A final quiet stretch of ones brings the link back through the latch-low sequence.

// File: rtl/far_fault_det.sv
module far_fault_det #(
  parameter int RUN_LEN   = 84,
  parameter int GROUPS    = 3,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int STAT_ADDR = 1,
  parameter int RF_BIT    = 4,
  parameter int LINK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int QUIET_LEN = RUN_LEN + 1;
  localparam int RUN_W     = $clog2(RUN_LEN + 2);
  localparam int QW        = $clog2(QUIET_LEN + 1);
  localparam int GW        = $clog2(GROUPS + 1);

  logic [RUN_W-1:0] run_q;
  logic [GW-1:0]    grp_q;
  logic [QW-1:0]    quiet_q;
  logic             rf_q, lat_q, live_q;
  logic [DATA_W-1:0] stat_word;

  wire term    = bit_vld & ~bit_in;
  wire good    = term && (run_q == RUN_W'(RUN_LEN));
  wire decl    = good && (grp_q == GW'(GROUPS - 1));
  wire stat_rd = rd_en && (rd_addr == ADDR_W'(STAT_ADDR));

  always_comb begin
    stat_word           = '0;
    stat_word[RF_BIT]   = rf_q;
    stat_word[LINK_BIT] = lat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      grp_q   <= '0;
      quiet_q <= '0;
      rf_q    <= 1'b0;
      lat_q   <= 1'b0;
      live_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (bit_vld) begin
        if (!bit_in)
          run_q <= '0;
        else if (run_q != RUN_W'(RUN_LEN + 1))
          run_q <= run_q + 1'b1;

        if (good)
          quiet_q <= '0;
        else if (quiet_q != QW'(QUIET_LEN))
          quiet_q <= quiet_q + 1'b1;
      end

      if (term)
        grp_q <= (good && !decl) ? grp_q + 1'b1 : '0;

      if (decl)
        live_q <= 1'b0;
      else if (quiet_q == QW'(QUIET_LEN))
        live_q <= 1'b1;

      if (decl)
        rf_q <= 1'b1;
      else if (stat_rd)
        rf_q <= 1'b0;

      if (decl)
        lat_q <= 1'b0;
      else if (stat_rd)
        lat_q <= live_q;

      rd_data <= stat_rd ? stat_word : '0;
    end
  end
endmodule

module far_fault_det_chk #(
  parameter int RUN_W  = 7,
  parameter int GW     = 2,
  parameter int GROUPS = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_vld,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [RUN_W-1:0]  run_q,
  input logic [GW-1:0]     grp_q,
  input logic              rf_q,
  input logic              lat_q,
  input logic              live_q,
  input logic              decl
);
  // R3
  rf_set_chk: assert property (@(posedge clk) disable iff (rst) decl |=> rf_q);
  // R4
  link_drop_chk: assert property (@(posedge clk) disable iff (rst) decl |=> (!live_q && !lat_q));
  // R5
  rf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(1) && !decl) |=> !rf_q);
  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != ADDR_W'(1)) |=> (rd_data == '0));
  // R10
  other_addr_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != ADDR_W'(1) && !decl) |=> ($stable(rf_q) && $stable(lat_q)));
  // R11
  idle_run_chk: assert property (@(posedge clk) disable iff (rst) !bit_vld |=> $stable(run_q));
  // R2
  grp_range_chk: assert property (@(posedge clk) disable iff (rst) grp_q < GW'(GROUPS));
  // R9
  reset_flags_chk: assert property (@(posedge clk) rst |=> (!rf_q && !lat_q && !live_q && rd_data == '0));
endmodule

bind far_fault_det far_fault_det_chk #(
  .RUN_W(RUN_W), .GW(GW), .GROUPS(GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .run_q(run_q), .grp_q(grp_q), .rf_q(rf_q), .lat_q(lat_q),
  .live_q(live_q), .decl(decl)
);

// File: tb/far_fault_det_test.sv
module far_fault_det_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic        bit_vld = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;
  string phase = "R9";
  bit finished = 1'b0;

  int m_run = 0, m_grp = 0, m_quiet = 0;
  bit m_rf = 0, m_lat = 0, m_live = 0;
  logic [15:0] m_exp = '0;

  always #4 clk = ~clk;

  far_fault_det uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    bit good, decl, rd1, old_live;
    int old_quiet;
    if (rst) begin
      m_run = 0; m_grp = 0; m_quiet = 0;
      m_rf = 0; m_lat = 0; m_live = 0; m_exp = '0;
    end else begin
      good = 0; decl = 0;
      rd1 = rd_en && rd_addr == 5'd1;
      old_live = m_live;
      old_quiet = m_quiet;
      m_exp = rd1 ? ((16'(m_rf) << 4) | (16'(m_lat) << 2)) : 16'h0;
      if (bit_vld) begin
        if (bit_in) begin
          if (m_run < 85) m_run++;
        end else begin
          good = (m_run == 84);
          m_run = 0;
          if (good && m_grp == 2) begin decl = 1; m_grp = 0; end
          else if (good) m_grp++;
          else m_grp = 0;
        end
        if (good) m_quiet = 0;
        else if (m_quiet < 85) m_quiet++;
      end
      if (decl) m_live = 0;
      else if (old_quiet == 85) m_live = 1;
      if (decl) m_rf = 1;
      else if (rd1) m_rf = 0;
      if (decl) m_lat = 0;
      else if (rd1) m_lat = old_live;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      tests++;
      if (rd_data !== m_exp) begin
        fails++;
        $display("FAIL %s model compare: rd_data=%h expected=%h", phase, rd_data, m_exp);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] exp);
    tests++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic send_bit(input bit b, input bit rd = 0);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1; rd_en = rd; rd_addr = 5'd1;
    @(negedge clk);
    bit_vld = 1'b0; rd_en = 1'b0;
  endtask

  task automatic send_ones(input int n, input bit gaps = 0);
    for (int i = 0; i < n; i++) begin
      send_bit(1'b1);
      if (gaps && (i % 10 == 3)) @(negedge clk);
    end
  endtask

  task automatic send_group(input int n, input bit gaps = 0);
    send_ones(n, gaps);
    send_bit(1'b0);
  endtask

  task automatic rd(input logic [4:0] a, input string req, input logic [15:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, exp);
    @(negedge clk);
    check("R12", 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9", 16'h0);
    rd(5'd1, "R9", 16'h0000);

    phase = "R8";
    send_ones(86);
    rd(5'd1, "R7", 16'h0000);
    rd(5'd1, "R8", 16'h0004);

    phase = "R1";
    send_bit(1'b0);
    send_group(84); send_group(84); send_group(83); send_group(84);
    rd(5'd1, "R1", 16'h0004);
    send_group(84); send_group(85); send_group(84);
    rd(5'd1, "R1", 16'h0004);

    phase = "R2";
    send_bit(1'b0);
    send_group(84); send_group(84);
    rd(5'd1, "R2", 16'h0004);

    phase = "R11";
    send_bit(1'b0);
    send_group(84, 1); send_group(84, 1); send_group(84, 1);
    rd(5'd1, "R3", 16'h0010);
    rd(5'd1, "R4", 16'h0000);

    phase = "R6";
    send_group(84); send_group(84);
    send_ones(84);
    send_bit(1'b0, 1'b1);
    check("R5", 16'h0000);
    rd(5'd0, "R10", 16'h0000);
    rd(5'd5, "R10", 16'h0000);
    rd(5'd1, "R6", 16'h0010);
    rd(5'd1, "R5", 16'h0000);

    phase = "R7";
    send_ones(86);
    rd(5'd1, "R7", 16'h0000);
    rd(5'd1, "R8", 16'h0004);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule